// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block holds the storage and the steering logic of a small 32-bit load/store processor that spends several clock cycles on each instruction. It keeps the program counter, an instruction register, a memory data register, two operand latches, an ALU result latch and a 32-entry register file. One ALU and one memory port are shared by every step of an instruction, so results that must survive into a later cycle are parked in these latches.

The datapath makes no decisions of its own. An external sequencer drives every multiplexer select and write enable each cycle, and reads back the opcode, the function field and an ALU zero flag to choose its next step. Memory is outside the block: the datapath presents one address and one write-data word, and takes one read-data word back. Load, store, register-to-register arithmetic, branch-if-equal and jump are all built from the same handful of strobes.

A typical instruction passes through a fetch cycle (load the instruction register, advance the PC by 4), a decode cycle (read both source registers, compute the branch target), an execute cycle, and for memory and arithmetic instructions one or two further cycles for the access and the register write.

Top module: `mcdp_top`

## Requirements
- R1: While `rst` is high the PC is set to `RESET_PC` (default 0) and every latch and register is cleared; after reset, with `addrSel` = 0, `memAddr` shows `RESET_PC`.
- R2: On a clock edge with `irWrite` = 1 the instruction register takes `memRdata`; `opcode` shows instruction bits 31:26 and `funct` bits 5:0, and both hold while `irWrite` = 0.
- R3: ALU operand one is the PC when `aluSrcA` = 0 and latch A when 1; operand two is selected by `aluSrcB`: 0 latch B, 1 the constant 4, 2 instruction bits 15:0 sign-extended, 3 that value shifted left by 2.
- R4: `aluOp` codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 signed set-less-than (result 1 or 0), 5 NOR, 6 and 7 add; `zero` is high exactly when the ALU result is 0.
- R5: The PC loads on an edge where `pcWrite` = 1, or where `pcWriteCond` = 1 and `zero` = 1, and otherwise holds; its source is chosen by `pcSrc`: 0 the live ALU result, 1 the ALU result latch, 2 the jump target {PC[31:28], instruction bits 25:0, 2'b00}, 3 the live ALU result.
- R6: `memAddr` is the PC when `addrSel` = 0 and the ALU result latch when 1; `memWdata` is always latch B.
- R7: Every cycle latch A takes register[instruction bits 25:21] and latch B register[bits 20:16]; on an edge with `regWrite` = 1 the register named by bits 15:11 (`regDst` = 1) or bits 20:16 (`regDst` = 0) is written with the ALU result latch (`memToReg` = 0) or the memory data register (`memToReg` = 1).
- R8: The memory data register and the ALU result latch capture `memRdata` and the ALU result on every edge, so a loaded word or computed value is written back on the following cycle.
- R9: Register 0 always reads as zero; writes addressed to it are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pcWrite | input | 1 | Unconditional PC load |
| pcWriteCond | input | 1 | PC load qualified by the zero flag |
| addrSel | input | 1 | Memory address source: 0 PC, 1 ALU result latch |
| irWrite | input | 1 | Instruction register load |
| regDst | input | 1 | Write register field: 0 bits 20:16, 1 bits 15:11 |
| memToReg | input | 1 | Write-back data: 0 ALU result latch, 1 memory data register |
| regWrite | input | 1 | Register file write enable |
| aluSrcA | input | 1 | ALU operand one: 0 PC, 1 latch A |
| aluSrcB | input | 2 | ALU operand two select |
| aluOp | input | 3 | ALU operation code |
| pcSrc | input | 2 | Next-PC source select |
| memRdata | input | 32 | Word read from memory |
| memAddr | output | 32 | Shared memory address |
| memWdata | output | 32 | Store data (latch B) |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |
| zero | output | 1 | ALU result equals zero |

## Verification
The bound checker watches the PC and the instruction register each cycle: the PC holds unless one of its write conditions is met, a fetch step advances it by exactly 4, a jump forms its target from the old PC and the instruction, reset forces the reset vector, and the instruction register follows memory only under its load strobe. Register contents, the ALU operation codes, sign extension of negative offsets, the register-0 rule and the taken and not-taken branch targets are only visible through stores and fetch addresses, so the bench runs a short program under a behavioural sequencer and its scoreboard compares every fetch address and every store against values worked out by hand.

// File: rtl/mcdp_pkg.sv
package mcdp_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4,
    ALU_NOR = 3'd5
  } aluOpE;

  typedef struct packed {
    logic       pcWrite;
    logic       pcWriteCond;
    logic       addrSel;
    logic       irWrite;
    logic       regDst;
    logic       memToReg;
    logic       regWrite;
    logic       aluSrcA;
    logic [1:0] aluSrcB;
    logic [2:0] aluOp;
    logic [1:0] pcSrc;
  } ctrlStrobes;

endpackage

// File: rtl/mcdp_regfile.sv
module mcdp_regfile #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] raddrA,
  input  logic [ADDR_W-1:0] raddrB,
  output logic [DATA_W-1:0] rdataA,
  output logic [DATA_W-1:0] rdataB,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [DEPTH];

  // Entry 0 is never written, so it stays at its reset value of zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdataA = (raddrA == '0) ? '0 : regs[raddrA];
  assign rdataB = (raddrB == '0) ? '0 : regs[raddrB];
endmodule

// File: rtl/mcdp_alu.sv
module mcdp_alu
  import mcdp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        op,
  output logic [DATA_W-1:0] result,
  output logic              isZero
);
  logic lessThan;

  assign lessThan = $signed(opA) < $signed(opB);

  always_comb begin
    case (op)
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(DATA_W-1){1'b0}}, lessThan};
      ALU_NOR: result = ~(opA | opB);
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);
endmodule

// File: rtl/mcdp_core.sv
module mcdp_core
  import mcdp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          REG_AW   = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobes  ctl,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero,
  output logic [31:0] pcView,
  output logic [31:0] irView
);
  localparam int DATA_W   = 32;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
  localparam int PC_TOP_W = DATA_W - JIDX_W - 2;

  logic [DATA_W-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ;
  logic [DATA_W-1:0] rdA, rdB, wrData, immSext, immShift;
  logic [DATA_W-1:0] srcA, srcB, aluY, jumpTarget, pcNext;
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic              pcEn;

  assign rsIdx = irQ[25:21];
  assign rtIdx = irQ[20:16];
  assign rdIdx = irQ[15:11];
  assign wrIdx = ctl.regDst ? rdIdx : rtIdx;
  assign wrData = ctl.memToReg ? mdrQ : aluOutQ;

  mcdp_regfile #(.ADDR_W(REG_AW), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .rst(rst),
    .raddrA(rsIdx), .raddrB(rtIdx),
    .rdataA(rdA), .rdataB(rdB),
    .we(ctl.regWrite), .waddr(wrIdx), .wdata(wrData)
  );

  assign immSext  = {{(DATA_W-IMM_W){irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign immShift = {immSext[DATA_W-3:0], 2'b00};

  assign srcA = ctl.aluSrcA ? aQ : pcQ;

  always_comb begin
    case (ctl.aluSrcB)
      2'd0:    srcB = bQ;
      2'd1:    srcB = DATA_W'(4);
      2'd2:    srcB = immSext;
      default: srcB = immShift;
    endcase
  end

  mcdp_alu #(.DATA_W(DATA_W)) u_alu (
    .opA(srcA), .opB(srcB), .op(ctl.aluOp),
    .result(aluY), .isZero(zero)
  );

  assign jumpTarget = {pcQ[DATA_W-1 -: PC_TOP_W], irQ[JIDX_W-1:0], 2'b00};

  always_comb begin
    case (ctl.pcSrc)
      2'd1:    pcNext = aluOutQ;
      2'd2:    pcNext = jumpTarget;
      default: pcNext = aluY;
    endcase
  end

  assign pcEn = ctl.pcWrite | (ctl.pcWriteCond & zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ     <= RESET_PC;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
    end else begin
      if (pcEn) pcQ <= pcNext;
      if (ctl.irWrite) irQ <= memRdata;
      mdrQ    <= memRdata;
      aQ      <= rdA;
      bQ      <= rdB;
      aluOutQ <= aluY;
    end
  end

  assign memAddr  = ctl.addrSel ? aluOutQ : pcQ;
  assign memWdata = bQ;
  assign opcode   = irQ[31:26];
  assign funct    = irQ[5:0];
  assign pcView   = pcQ;
  assign irView   = irQ;
endmodule

// File: rtl/mcdp_top.sv
module mcdp_top
  import mcdp_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        pcWrite,
  input  logic        pcWriteCond,
  input  logic        addrSel,
  input  logic        irWrite,
  input  logic        regDst,
  input  logic        memToReg,
  input  logic        regWrite,
  input  logic        aluSrcA,
  input  logic [1:0]  aluSrcB,
  input  logic [2:0]  aluOp,
  input  logic [1:0]  pcSrc,
  input  logic [31:0] memRdata,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  ctrlStrobes  ctl;
  logic [31:0] pcView, irView;

  assign ctl.pcWrite     = pcWrite;
  assign ctl.pcWriteCond = pcWriteCond;
  assign ctl.addrSel     = addrSel;
  assign ctl.irWrite     = irWrite;
  assign ctl.regDst      = regDst;
  assign ctl.memToReg    = memToReg;
  assign ctl.regWrite    = regWrite;
  assign ctl.aluSrcA     = aluSrcA;
  assign ctl.aluSrcB     = aluSrcB;
  assign ctl.aluOp       = aluOp;
  assign ctl.pcSrc       = pcSrc;

  mcdp_core #(.RESET_PC(RESET_PC)) u_core (
    .clk(clk), .rst(rst), .ctl(ctl), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct), .zero(zero),
    .pcView(pcView), .irView(irView)
  );
endmodule

// File: rtl/mcdp_checker.sv
module mcdp_checker #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input logic        clk,
  input logic        rst,
  input logic        pcWrite,
  input logic        pcWriteCond,
  input logic        irWrite,
  input logic        aluSrcA,
  input logic [1:0]  aluSrcB,
  input logic [2:0]  aluOp,
  input logic [1:0]  pcSrc,
  input logic [31:0] memRdata,
  input logic [5:0]  opcode,
  input logic [5:0]  funct,
  input logic        zero,
  input logic [31:0] pcCur,
  input logic [31:0] irCur
);
  // R1
  reset_vector_chk: assert property (@(posedge clk)
    rst |=> (pcCur == RESET_PC));

  // R2
  ir_load_chk: assert property (@(posedge clk) disable iff (rst)
    irWrite |=> (opcode == $past(memRdata[31:26])) && (funct == $past(memRdata[5:0])));

  // R2
  ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !irWrite |=> $stable(opcode) && $stable(funct));

  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!pcWrite && !(pcWriteCond && zero)) |=> $stable(pcCur));

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && !aluSrcA && aluSrcB == 2'd1 && aluOp == 3'd0 && pcSrc == 2'd0)
      |=> (pcCur == $past(pcCur) + 32'd4));

  // R5
  jump_target_chk: assert property (@(posedge clk) disable iff (rst)
    (pcWrite && pcSrc == 2'd2)
      |=> (pcCur == {$past(pcCur[31:28]), $past(irCur[25:0]), 2'b00}));
endmodule

bind mcdp_top mcdp_checker #(.RESET_PC(RESET_PC)) u_chk (
  .clk(clk), .rst(rst), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
  .irWrite(irWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
  .pcSrc(pcSrc), .memRdata(memRdata), .opcode(opcode), .funct(funct),
  .zero(zero), .pcCur(pcView), .irCur(irView)
);

// File: tb/sim_mcdp_top.sv
`timescale 1ns/1ps
module sim_mcdp_top;
  localparam int HALF = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pcWrite, pcWriteCond, addrSel, irWrite, regDst, memToReg, regWrite, aluSrcA;
  logic [1:0]  aluSrcB, pcSrc;
  logic [2:0]  aluOp;
  logic [31:0] memRdata, memAddr, memWdata;
  logic [5:0]  opcode, funct;
  logic        zero;
  logic        memWr;

  logic [31:0] mem [0:255];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit          isStore;
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } sbItem;
  sbItem sbQ[$];

  always #HALF clk = ~clk;

  mcdp_top u0 (
    .clk(clk), .rst(rst), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .addrSel(addrSel), .irWrite(irWrite), .regDst(regDst), .memToReg(memToReg),
    .regWrite(regWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
    .pcSrc(pcSrc), .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  assign memRdata = mem[memAddr[9:2]];
  always @(posedge clk) if (memWr) mem[memAddr[9:2]] <= memWdata;

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops scoreboard items as fetches and stores happen.
  always @(negedge clk) begin
    if (!rst && (irWrite || memWr)) begin
      if (sbQ.size() == 0) begin
        checkEq("R6 unexpected memory event", memAddr, 32'hFFFF_FFFF);
      end else begin
        sbItem it;
        it = sbQ.pop_front();
        if (it.isStore != memWr) begin
          checkEq({it.tag, " event kind"}, {31'd0, memWr}, {31'd0, it.isStore});
        end else begin
          checkEq({it.tag, " address"}, memAddr, it.addr);
          if (it.isStore) checkEq({it.tag, " data"}, memWdata, it.data);
        end
      end
    end
  end

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encJ(input logic [25:0] idx);
    return {6'd2, idx};
  endfunction

  function automatic logic [2:0] functToOp(input logic [5:0] fn);
    case (fn)
      6'd32: return 3'd0;
      6'd34: return 3'd1;
      6'd36: return 3'd2;
      6'd37: return 3'd3;
      6'd42: return 3'd4;
      6'd39: return 3'd5;
      default: return 3'd7;
    endcase
  endfunction

  task automatic clearCtrl();
    pcWrite = 0; pcWriteCond = 0; addrSel = 0; irWrite = 0; regDst = 0;
    memToReg = 0; regWrite = 0; aluSrcA = 0; aluSrcB = 0; aluOp = 0; pcSrc = 0; memWr = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Sequencer for one instruction; pushes the fetch (and store) expectations.
  task automatic runInstr(input logic [31:0] expPc, input string tag,
                          input logic [31:0] stAddr = 0, input logic [31:0] stData = 0,
                          input bit expZero = 0);
    logic [31:0] ins;
    sbItem it;
    ins = mem[expPc[9:2]];
    it.isStore = 0; it.addr = expPc; it.data = 0; it.tag = {"R5 fetch pc ", tag};
    sbQ.push_back(it);
    clearCtrl();
    irWrite = 1; pcWrite = 1; aluSrcB = 2'd1;
    tick();
    checkEq({"R2 opcode ", tag}, {26'd0, opcode}, {26'd0, ins[31:26]});
    checkEq({"R2 funct ", tag}, {26'd0, funct}, {26'd0, ins[5:0]});
    clearCtrl();
    aluSrcB = 2'd3;
    tick();
    clearCtrl();
    case (ins[31:26])
      6'd35, 6'd43: begin
        aluSrcA = 1; aluSrcB = 2'd2;
        tick();
        clearCtrl();
        addrSel = 1;
        if (ins[31:26] == 6'd43) begin
          it.isStore = 1; it.addr = stAddr; it.data = stData; it.tag = {"R7 store ", tag};
          sbQ.push_back(it);
          memWr = 1;
          tick();
        end else begin
          tick();
          clearCtrl();
          memToReg = 1; regWrite = 1;
          tick();
        end
      end
      6'd0: begin
        aluSrcA = 1; aluOp = functToOp(ins[5:0]);
        tick();
        clearCtrl();
        regDst = 1; regWrite = 1;
        tick();
      end
      6'd4: begin
        aluSrcA = 1; aluOp = 3'd1; pcWriteCond = 1; pcSrc = 2'd1;
        #5;
        checkEq({"R4 zero flag ", tag}, {31'd0, zero}, {31'd0, expZero});
        tick();
      end
      default: begin
        pcWrite = 1; pcSrc = 2'd2;
        tick();
      end
    endcase
    clearCtrl();
  endtask

  initial begin
    #(HALF * 2 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = encI(6'd43, 5'd0, 5'd1, 16'd0);
    mem[0]  = encI(6'd35, 5'd0, 5'd1, 16'd256);
    mem[1]  = encI(6'd35, 5'd0, 5'd2, 16'd260);
    mem[2]  = encR(5'd1, 5'd2, 5'd3, 6'd32);
    mem[3]  = encI(6'd43, 5'd0, 5'd3, 16'd512);
    mem[4]  = encR(5'd1, 5'd2, 5'd4, 6'd34);
    mem[5]  = encI(6'd43, 5'd0, 5'd4, 16'd516);
    mem[6]  = encR(5'd2, 5'd1, 5'd5, 6'd42);
    mem[7]  = encI(6'd43, 5'd0, 5'd5, 16'd520);
    mem[8]  = encR(5'd1, 5'd2, 5'd6, 6'd36);
    mem[9]  = encR(5'd1, 5'd2, 5'd7, 6'd37);
    mem[10] = encI(6'd43, 5'd0, 5'd6, 16'd524);
    mem[11] = encI(6'd43, 5'd0, 5'd7, 16'd528);
    mem[12] = encR(5'd1, 5'd1, 5'd0, 6'd32);
    mem[13] = encI(6'd43, 5'd0, 5'd0, 16'd532);
    mem[14] = encI(6'd4, 5'd1, 5'd2, 16'd5);
    mem[15] = encI(6'd43, 5'd0, 5'd1, 16'd536);
    mem[16] = encI(6'd4, 5'd1, 5'd1, 16'd2);
    mem[19] = encI(6'd43, 5'd0, 5'd2, 16'd540);
    mem[20] = encJ(26'd30);
    mem[30] = encI(6'd35, 5'd0, 5'd8, 16'd264);
    mem[31] = encI(6'd43, 5'd8, 5'd1, 16'hFFF8);
    mem[32] = encR(5'd1, 5'd0, 5'd9, 6'd39);
    mem[33] = encR(5'd1, 5'd2, 5'd10, 6'd33);
    mem[34] = encI(6'd43, 5'd0, 5'd9, 16'd544);
    mem[35] = encI(6'd43, 5'd0, 5'd10, 16'd548);
    mem[36] = encR(5'd1, 5'd2, 5'd11, 6'd42);
    mem[37] = encI(6'd43, 5'd0, 5'd11, 16'd552);
    mem[64] = 32'd7;
    mem[65] = 32'hFFFF_FFFD;
    mem[66] = 32'd600;

    clearCtrl();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    #4;
    // R1: reset vector on the address port
    checkEq("R1 reset pc on memAddr", memAddr, 32'd0);
    checkEq("R1 opcode cleared", {26'd0, opcode}, 32'd0);

    runInstr(0,  "lw r1");
    runInstr(4,  "lw r2");
    runInstr(8,  "add");
    runInstr(12, "R8 load+add result", 512, 32'd4);
    runInstr(16, "sub");
    runInstr(20, "R4 sub", 516, 32'd10);
    runInstr(24, "slt");
    runInstr(28, "R4 slt true", 520, 32'd1);
    runInstr(32, "and");
    runInstr(36, "or");
    runInstr(40, "R4 and", 524, 32'd5);
    runInstr(44, "R4 or", 528, 32'hFFFF_FFFF);
    runInstr(48, "write r0");
    runInstr(52, "R9 r0 stays zero", 532, 32'd0);
    runInstr(56, "beq not taken", 0, 0, 1'b0);
    runInstr(60, "R5 fallthrough", 536, 32'd7);
    runInstr(64, "beq taken", 0, 0, 1'b1);
    runInstr(76, "R3 branch target", 540, 32'hFFFF_FFFD);
    runInstr(80, "jump");
    runInstr(120, "lw r8");
    runInstr(124, "R3 negative offset", 592, 32'd7);
    runInstr(128, "nor");
    runInstr(132, "op7 add");
    runInstr(136, "R4 nor", 544, 32'hFFFF_FFF8);
    runInstr(140, "R4 code 7 adds", 548, 32'd4);
    runInstr(144, "slt false");
    runInstr(148, "R4 signed slt", 552, 32'd0);

    @(negedge clk);
    // R6: everything pushed was consumed by the monitor
    checkEq("R6 scoreboard drained", sbQ.size(), 0);
    // R7: stored word landed in memory at the ALU-latch address
    checkEq("R7 memory contents", mem[148], 32'd7);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule